// File: doc/BRIEF.md
# PWM Chopper with Wide Leading Pulse

This block sits after a PWM generator and breaks each high phase of the PWM signal into a high-frequency pulse train. Such a train can pass through a pulse transformer or a capacitive gate-drive coupler, which cannot carry a long steady level. Every high phase opens with one wide leading pulse, so that the isolated driver charges quickly. A carrier derived from the module clock then gates the rest of that phase. Deadtime insertion takes place upstream and is not part of this block.

All timing uses a base of sixteen module clock cycles. The leading pulse lasts a whole number of those sixteen-cycle steps. The carrier period is also a multiple of sixteen cycles, from 16 to 256. The carrier high time is set in eighths of the carrier period. The block samples its settings only when a new high phase begins. When chopping is off, the block passes the PWM signal through a single register.

Top module: `pwm_chopper`

## Requirements
- R1: While reset is held low with the PWM input low, the output is low. After reset is released, the first high cycle of the input starts a complete new high phase, leading pulse included.
- R2: With `chop_en` low, `pwm_out` in each cycle equals the value that `pwm_in` had in the previous clock cycle. This value is 0 just after reset.
- R3: With `chop_en` high, the output is high from the first cycle in which `pwm_in` is seen high. It stays high for (`first_sel` + 1) × 16 cycles, counted from that cycle, or until the input falls.
- R4: The carrier period is (`div_sel` + 1) × 16 cycles. Its phase counter restarts at 0 in the rising cycle of `pwm_in`. After the leading pulse, the output at t cycles after the rise follows the carrier phase t mod period.
- R5: The carrier is high while its phase is below (`duty_sel` + 1) × period / 8, and low for the rest of the period.
- R6: A `duty_sel` of 7 gives a continuous high output for the whole high phase of the input.
- R7: With `chop_en` high, the output is low in every cycle in which `pwm_in` is low, including the very cycle in which it falls. This holds during the leading pulse and during the carrier.
- R8: `div_sel`, `duty_sel` and `first_sel` are sampled only in the rising cycle of `pwm_in`. A change of these inputs during a high phase has no effect on the output until the next rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 1 | PWM signal to be chopped |
| chop_en | input | 1 | 1 = chop the high phases, 0 = pass the input through with one cycle of delay |
| div_sel | input | 4 | Carrier period in steps of 16 cycles, minus one |
| duty_sel | input | 3 | Carrier high time in eighths of the period, minus one |
| first_sel | input | 4 | Leading pulse width in steps of 16 cycles, minus one |
| pwm_out | output | 1 | Chopped PWM signal |

## Verification
The main function is exercised with several settings: the shortest period with half duty, a four-step period with quarter duty after a three-step leading pulse, the longest period with the narrowest duty and the widest leading pulse, and full duty. Together these separate a wrong period, a wrong high time and a wrong leading width. Each one shows up as an output that differs at a known cycle after the rise. An input that falls inside the leading pulse tests the immediate cutoff apart from the normal end of the pulse. A test that changes the settings in the middle of a phase, followed by a second phase, tells sampling at the rise apart from live use of the inputs. A pass-through pattern with isolated single-cycle highs confirms the bypass delay.

// File: rtl/chop_pkg.sv
// Package: shared sizes for the PWM chopper.
// Assumes a time base of 2**PRE_W module clock cycles (16 by default).
package chop_pkg;
    localparam int PRE_W   = 4;   // log2 of the time base step
    localparam int DIV_W   = 4;   // carrier divider field width
    localparam int DUTY_W  = 3;   // duty field width (eighths)
    localparam int FIRST_W = 4;   // leading pulse field width
    // width of a carrier phase value: divider steps times time base
    localparam int PHASE_W = DIV_W + PRE_W;
endpackage

// File: rtl/chop_prescale.sv
// Module: chop_prescale
// Free-running time base counter that restarts on request.
// The restart cycle counts as phase 0, so the register is loaded with 1 there.
// Assumes the counter wraps naturally at 2**PRE_W.
module chop_prescale #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [PRE_W-1:0] phase,
    output logic             tick
);
    localparam logic [PRE_W-1:0] LAST = '1;

    // Advance the time base; restart makes the next cycle phase 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= PRE_W'(1);
        else              phase <= phase + 1'b1;
    end

    // One-cycle pulse in the last cycle of each time base step.
    always_comb tick = (phase == LAST);
endmodule

// File: rtl/chop_first.sv
// Module: chop_first
// Holds the leading-pulse flag for (width + 1) time base steps after a restart.
// Assumes that tick falls in the last cycle of each step and that width is stable
// while the flag is set.
module chop_first #(
    parameter int FIRST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               tick,
    input  logic [FIRST_W-1:0] width,
    output logic               active
);
    logic [FIRST_W-1:0] steps;

    // Count finished steps and drop the flag after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            steps  <= '0;
        end else if (restart) begin
            active <= 1'b1;
            steps  <= '0;
        end else if (active && tick) begin
            if (steps == width) active <= 1'b0;
            else                steps  <= steps + 1'b1;
        end
    end
endmodule

// File: rtl/chop_carrier.sv
// Module: chop_carrier
// Carrier generator: period (div + 1) time base steps, high for the first
// (duty + 1) eighths of it. Phase 0 falls in the restart cycle.
// Assumes the duty field is DUTY_W bits wide, so the full scale is 2**DUTY_W.
module chop_carrier #(
    parameter int PRE_W  = 4,
    parameter int DIV_W  = 4,
    parameter int DUTY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [PRE_W-1:0]  sub,
    input  logic [DIV_W-1:0]  div,
    input  logic [DUTY_W-1:0] duty,
    output logic              high
);
    localparam int PH_W = DIV_W + PRE_W;
    localparam int TH_W = PH_W + DUTY_W + 2;

    logic [DIV_W-1:0] step;
    logic [PH_W-1:0]  phase;
    logic [TH_W-1:0]  thresh;

    // Count time base steps within one carrier period.
    always_ff @(posedge clk) begin
        if (!rst_n)            step <= '0;
        else if (restart)      step <= '0;
        else if (tick) begin
            if (step == div)   step <= '0;
            else               step <= step + 1'b1;
        end
    end

    // Phase within the period and the threshold for the high part.
    always_comb begin
        phase  = {step, sub};
        thresh = TH_W'((TH_W'(duty) + 1'b1) * (TH_W'(div) + 1'b1)) << (PRE_W - DUTY_W);
        high   = (TH_W'(phase) < thresh);
    end
endmodule

// File: rtl/pwm_chopper.sv
// Module: pwm_chopper (top)
// Chops the high phases of a PWM signal: a wide leading pulse, then a carrier.
// The settings are sampled in the rising cycle of pwm_in. The output falls in the
// same cycle as pwm_in. When chopping is off, the output is pwm_in delayed by one register.
// Assumes pwm_in is synchronous to clk.
module pwm_chopper
    import chop_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwm_in,
    input  logic               chop_en,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic [DUTY_W-1:0]  duty_sel,
    input  logic [FIRST_W-1:0] first_sel,
    output logic               pwm_out
);
    logic               pwm_d;
    logic               rise;
    logic [DIV_W-1:0]   div_q;
    logic [DUTY_W-1:0]  duty_q;
    logic [FIRST_W-1:0] first_q;
    logic [PRE_W-1:0]   sub;
    logic               tick;
    logic               lead_on;
    logic               car_hi;

    // Input history for edge detection and for the bypass path.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_d <= 1'b0;
        else        pwm_d <= pwm_in;
    end

    // Rising cycle of the PWM input.
    always_comb rise = pwm_in & ~pwm_d;

    // Sample the settings only when a new high phase begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            duty_q  <= '0;
            first_q <= '0;
        end else if (rise) begin
            div_q   <= div_sel;
            duty_q  <= duty_sel;
            first_q <= first_sel;
        end
    end

    chop_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(rise), .phase(sub), .tick(tick)
    );

    chop_first #(.FIRST_W(FIRST_W)) u_first (
        .clk(clk), .rst_n(rst_n), .restart(rise), .tick(tick),
        .width(first_q), .active(lead_on)
    );

    chop_carrier #(.PRE_W(PRE_W), .DIV_W(DIV_W), .DUTY_W(DUTY_W)) u_car (
        .clk(clk), .rst_n(rst_n), .restart(rise), .tick(tick), .sub(sub),
        .div(div_q), .duty(duty_q), .high(car_hi)
    );

    // Output select: gated input when chopping, registered input otherwise.
    always_comb begin
        if (chop_en) pwm_out = pwm_in & (rise | lead_on | car_hi);
        else         pwm_out = pwm_d;
    end
endmodule

// File: rtl/pwm_chopper_chk.sv
// Module: pwm_chopper_chk
// Checker bound to pwm_chopper. It keeps its own record of the input and its own
// count of the cycles since each rise.
module pwm_chopper_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_in,
    input logic chop_en,
    input logic pwm_out
);
    logic       prv;
    logic [4:0] hc;

    // Previous input and the count of high cycles since the rise, held at 16.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv <= 1'b0;
            hc  <= '0;
        end else begin
            prv <= pwm_in;
            if (!pwm_in)                hc <= '0;
            else if (!prv)              hc <= 5'd1;
            else if (hc != 0 && hc < 16) hc <= hc + 1'b1;
        end
    end

    AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        !chop_en |-> pwm_out == prv);                                   // R2
    AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        chop_en && pwm_in && !prv |-> pwm_out);                         // R3
    AST_LEAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        chop_en && pwm_in && hc != 0 && hc < 16 |-> pwm_out);           // R3
    AST_LOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        chop_en && !pwm_in |-> !pwm_out);                               // R7
endmodule

bind pwm_chopper pwm_chopper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .chop_en(chop_en), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_chopper.sv
// Scoreboard bench: the driver computes each expected output from the
// requirements and queues it, and the monitor compares it with the output.
module tb_pwm_chopper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic       chop_en = 1'b0;
    logic [3:0] div_sel = '0;
    logic [2:0] duty_sel = '0;
    logic [3:0] first_sel = '0;
    logic       pwm_out;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model state
    bit prev_m = 1'b0;
    int t_m = 0, f_m = 0, d_m = 0, y_m = 0;

    always #5 clk = ~clk;

    pwm_chopper dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .chop_en(chop_en),
        .div_sel(div_sel), .duty_sel(duty_sel), .first_sel(first_sel),
        .pwm_out(pwm_out)
    );

    // Driver: one cycle of stimulus and the output the requirements call for.
    task automatic step(input bit pwm, input string tag);
        item_t it;
        int per, hi, wid;
        @(negedge clk);
        pwm_in = pwm;
        if (pwm && !prev_m) begin
            t_m = 0; f_m = first_sel; d_m = div_sel; y_m = duty_sel;   // R8
        end else if (pwm) t_m++;
        per = 16 * (d_m + 1);
        hi  = (y_m + 1) * per / 8;
        wid = 16 * (f_m + 1);
        if (!chop_en) begin
            it.exp = prev_m; it.tag = (tag == "R1") ? "R1" : "R2";
        end else begin
            it.exp = pwm && (t_m < wid || (t_m % per) < hi);
            if (tag == "R1" || tag == "R8") it.tag = tag;
            else if (!pwm)      it.tag = "R7";
            else if (t_m < wid) it.tag = "R3";
            else                it.tag = tag;
        end
        prev_m = rst_n ? pwm : 1'b0;
        q.push_back(it);
    endtask

    task automatic phase(input int nhi, input int nlo, input string tag);
        for (int i = 0; i < nhi; i++) step(1'b1, tag);
        for (int i = 0; i < nlo; i++) step(1'b0, tag);
    endtask

    // Monitor: sample shortly after the driving edge, compare with the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (pwm_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s at %0t: pwm_out=%b expected %b", it.tag, $time, pwm_out, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset with input low, then release
        chop_en = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        q.push_back('{exp: 1'b0, tag: "R1"});
        prev_m = 1'b0;
        // R1: first high phase after release gets its leading pulse
        phase(20, 3, "R1");

        // R2: bypass with single-cycle and longer highs
        chop_en = 1'b0;
        phase(1, 1, "R2"); phase(3, 2, "R2"); phase(1, 4, "R2"); phase(40, 3, "R2");

        // R5: shortest period, half duty
        chop_en = 1'b1;
        first_sel = 4'd0; div_sel = 4'd0; duty_sel = 3'd3;
        phase(80, 10, "R5");

        // R4: period of 64 cycles after a 48-cycle leading pulse, quarter duty
        first_sel = 4'd2; div_sel = 4'd3; duty_sel = 3'd1;
        phase(150, 5, "R4");

        // R6: full duty stays high
        first_sel = 4'd0; div_sel = 4'd1; duty_sel = 3'd7;
        phase(70, 4, "R6");

        // R7: fall inside the leading pulse
        first_sel = 4'd3;
        phase(20, 6, "R7");

        // R8: settings changed mid-phase are ignored until the next rise
        first_sel = 4'd0; div_sel = 4'd0; duty_sel = 3'd1;
        phase(3, 0, "R8");
        first_sel = 4'd5; div_sel = 4'd7; duty_sel = 3'd6;
        phase(70, 4, "R8");
        phase(120, 4, "R8");

        // R4: longest period, narrowest duty, widest leading pulse
        first_sel = 4'd15; div_sel = 4'd15; duty_sel = 3'd0;
        phase(600, 5, "R4");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule